// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block turns a single transaction descriptor into an ordered series of byte-level bus operations for an I2C master. A descriptor carries a 7-bit target address, a flag that makes the command byte the write payload, a write count, a read count, a direction bit, a buffer pointer, and two mode bits (block transfer and packet error code) that must both be clear. Once a descriptor is accepted, the sequencer issues start, address, data, repeated-start and stop operations to a separate bit-level bus engine. It takes one operation at a time and waits for that engine's completion strobe before moving on.

Transmit bytes are fetched from a shared byte buffer starting at the descriptor pointer. Received bytes are written back through that same pointer, so in a combined write-then-read transfer the read data overwrites the bytes that were sent. The descriptor is checked before anything reaches the bus. An illegal descriptor is refused with an error flag and never starts a bus operation. A target that does not acknowledge ends the transfer early with a stop and a separate error flag.

Top module: `i2c_desc_seq`

## Requirements
- R1: A descriptor with the command flag set, both counts zero and the direction bit 0 produces, in this order: start, address byte, one data byte equal to the command field, stop.
- R2: A descriptor with the command flag clear, write count of two or more, read count zero and direction bit 0 sends the buffer bytes at pointer+0 up to pointer+count-1 in ascending order. Buffer addresses wrap modulo the buffer size.
- R3: A descriptor with the command flag clear, write count zero, read count of one or more and direction bit 1 produces start, address byte with bit0 = 1, then the reads. Read byte i is stored at buffer address pointer+i.
- R4: A descriptor with the command flag clear, write count of one or more, read count of one or more and direction bit 1 produces start, address byte with bit0 = 0, the writes, a repeated start, address byte with bit0 = 1, the reads and stop. Read byte i overwrites buffer address pointer+i.
- R5: During every read except the last, `bus_rd_nack` is 0 (the master acknowledges). During the last read it is 1.
- R6: Any other descriptor, or any descriptor with the block bit or the PEC bit set, raises `err_desc` and pulses `done` on the cycle after acceptance. It starts no bus operation and leaves `busy` low.
- R7: If the target answers an address byte or a written byte with NACK, the next operation is stop, no further byte is issued, and `err_nack` is 1 when `done` pulses.
- R8: `busy` rises on the cycle after a legal descriptor is accepted and stays high until the stop completes. `done` is a one-cycle pulse in the cycle after the stop completes, with `busy` low. A `desc_valid` while `busy` is high is ignored.
- R9: Operation codes on `bus_op` are start = 0, write byte = 1, read byte = 2, repeated start = 3, stop = 4. An address byte is a write byte whose value is {address[6:0], direction}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered this cycle (taken when idle) |
| desc_addr | input | 7 | 7-bit target address |
| desc_cmd_data | input | 1 | Command field is the single write byte |
| desc_cmd | input | 8 | Command byte |
| desc_wr_len | input | LEN_W | Number of bytes to write from the buffer |
| desc_rd_len | input | LEN_W | Number of bytes to read |
| desc_rw | input | 1 | Direction bit (1 = transfer contains reads) |
| desc_blk | input | 1 | Block-transfer mode bit (must be 0) |
| desc_pec | input | 1 | Packet error code bit (must be 0) |
| desc_ptr | input | PTR_W | Buffer start address for both directions |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-descriptor pulse |
| err_desc | output | 1 | Last descriptor was illegal |
| err_nack | output | 1 | Last transfer ended on a target NACK |
| bus_req | output | 1 | Operation request to the bus engine |
| bus_op | output | 3 | Operation code (see R9) |
| bus_wdata | output | 8 | Byte to send for a write operation |
| bus_rd_nack | output | 1 | Answer this read with NACK (last byte) |
| bus_done | input | 1 | Engine finished the current operation |
| bus_nack | input | 1 | Target did not acknowledge the written byte |
| bus_rdata | input | 8 | Received byte, valid with `bus_done` |
| buf_addr | output | PTR_W | Buffer address (read combinationally, written on `buf_we`) |
| buf_rdata | input | 8 | Buffer byte at `buf_addr` |
| buf_we | output | 1 | Buffer write strobe for a received byte |
| buf_wdata | output | 8 | Byte written into the buffer |

## Verification
In a combined transfer, the completion of the final written byte is also the point where the sequencer would move on to the repeated start. A target NACK can arrive on exactly that byte, so abort and phase change compete in the same cycle. The bench provokes this with its engine model, which refuses the last write of a combined descriptor. It judges the result from the recorded operation trace: stop must follow directly, with no repeated start and no read. It also checks that `err_nack` is set and that the buffer is untouched. A second overlap, a new descriptor offered while a transfer is running, is judged by an unchanged trace and a clear `err_desc`.

// File: rtl/i2c_desc_pkg.sv
// Shared types for the descriptor-driven I2C master sequencer.
// Assumes: operation codes are decoded by an external byte-level bus engine.
package i2c_desc_pkg;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_RSTART = 3'd3,
        OP_STOP   = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {
        K_CMD1  = 2'd0,
        K_WRITE = 2'd1,
        K_READ  = 2'd2,
        K_COMBO = 2'd3
    } xfer_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_ADDR_W, S_WRITE, S_RSTART, S_ADDR_R, S_READ, S_STOP
    } seq_state_e;

endpackage

// File: rtl/i2c_desc_check.sv
// Descriptor legality decoder: classifies a descriptor into one of four
// legal transfer kinds or flags it illegal. Purely combinational.
// Assumes: block and PEC bits must both be clear for any I2C transfer.
module i2c_desc_check
    import i2c_desc_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             cmd_data,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [LEN_W-1:0] rd_len,
    input  logic             rw,
    input  logic             blk,
    input  logic             pec,
    output logic             legal,
    output xfer_kind_e       kind
);

    logic wr_zero, rd_zero, wr_many;

    // Length predicates shared by the kind decode.
    always_comb begin
        wr_zero = (wr_len == '0);
        rd_zero = (rd_len == '0);
        wr_many = !wr_zero && (wr_len != LEN_W'(1));
    end

    // Match the four legal shapes; anything else is refused.
    always_comb begin
        legal = 1'b0;
        kind  = K_CMD1;
        if (!blk && !pec) begin
            if (cmd_data && wr_zero && rd_zero && !rw) begin
                legal = 1'b1; kind = K_CMD1;
            end else if (!cmd_data && wr_many && rd_zero && !rw) begin
                legal = 1'b1; kind = K_WRITE;
            end else if (!cmd_data && wr_zero && !rd_zero && rw) begin
                legal = 1'b1; kind = K_READ;
            end else if (!cmd_data && !wr_zero && !rd_zero && rw) begin
                legal = 1'b1; kind = K_COMBO;
            end
        end
    end

endmodule

// File: rtl/i2c_buf_port.sv
// Buffer port: forms the shared buffer address from the descriptor pointer
// and the current byte index, and raises the write strobe for received bytes.
// Assumes: buffer read is combinational; addresses wrap modulo 2**PTR_W.
module i2c_buf_port #(
    parameter int PTR_W = 6,
    parameter int LEN_W = 6
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [LEN_W-1:0] idx,
    input  logic             capture,
    input  logic [7:0]       rx_byte,
    output logic [PTR_W-1:0] addr,
    output logic             we,
    output logic [7:0]       wdata
);

    // One pointer serves both directions, so reads land on the sent bytes.
    always_comb begin
        addr  = ptr + PTR_W'(idx);
        we    = capture;
        wdata = rx_byte;
    end

endmodule

// File: rtl/i2c_desc_seq.sv
// Descriptor-driven I2C master sequencer (top). Accepts a descriptor when
// idle, checks it, then walks start / address / data / repeated start /
// stop operations, one per engine completion strobe.
// Assumes: the bus engine holds bus_done for exactly one cycle per request
// and presents bus_nack / bus_rdata alongside it.
module i2c_desc_seq
    import i2c_desc_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    input  logic [6:0]       desc_addr,
    input  logic             desc_cmd_data,
    input  logic [7:0]       desc_cmd,
    input  logic [LEN_W-1:0] desc_wr_len,
    input  logic [LEN_W-1:0] desc_rd_len,
    input  logic             desc_rw,
    input  logic             desc_blk,
    input  logic             desc_pec,
    input  logic [PTR_W-1:0] desc_ptr,
    output logic             busy,
    output logic             done,
    output logic             err_desc,
    output logic             err_nack,
    output logic             bus_req,
    output logic [2:0]       bus_op,
    output logic [7:0]       bus_wdata,
    output logic             bus_rd_nack,
    input  logic             bus_done,
    input  logic             bus_nack,
    input  logic [7:0]       bus_rdata,
    output logic [PTR_W-1:0] buf_addr,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [7:0]       buf_wdata
);

    seq_state_e       state;
    xfer_kind_e       kind_d, kind_q;
    logic             legal;
    logic [6:0]       addr_q;
    logic [7:0]       cmd_q;
    logic             cmd_data_q;
    logic [LEN_W-1:0] wr_len_q, rd_len_q, idx_q;
    logic [PTR_W-1:0] ptr_q;
    logic             last_wr, last_rd;

    i2c_desc_check #(.LEN_W(LEN_W)) u_check (
        .cmd_data (desc_cmd_data),
        .wr_len   (desc_wr_len),
        .rd_len   (desc_rd_len),
        .rw       (desc_rw),
        .blk      (desc_blk),
        .pec      (desc_pec),
        .legal    (legal),
        .kind     (kind_d)
    );

    i2c_buf_port #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_buf (
        .ptr     (ptr_q),
        .idx     (idx_q),
        .capture (state == S_READ && bus_done),
        .rx_byte (bus_rdata),
        .addr    (buf_addr),
        .we      (buf_we),
        .wdata   (buf_wdata)
    );

    // Last-byte detection for the write and read phases.
    always_comb begin
        last_wr = cmd_data_q || (idx_q == wr_len_q - LEN_W'(1));
        last_rd = (idx_q == rd_len_q - LEN_W'(1));
    end

    // Sequencer state, latched descriptor and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            kind_q     <= K_CMD1;
            busy       <= 1'b0;
            done       <= 1'b0;
            err_desc   <= 1'b0;
            err_nack   <= 1'b0;
            addr_q     <= '0;
            cmd_q      <= '0;
            cmd_data_q <= 1'b0;
            wr_len_q   <= '0;
            rd_len_q   <= '0;
            ptr_q      <= '0;
            idx_q      <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (desc_valid) begin
                    err_nack <= 1'b0;
                    if (legal) begin
                        kind_q     <= kind_d;
                        addr_q     <= desc_addr;
                        cmd_q      <= desc_cmd;
                        cmd_data_q <= desc_cmd_data;
                        wr_len_q   <= desc_wr_len;
                        rd_len_q   <= desc_rd_len;
                        ptr_q      <= desc_ptr;
                        err_desc   <= 1'b0;
                        busy       <= 1'b1;
                        state      <= S_START;
                    end else begin
                        err_desc <= 1'b1;
                        done     <= 1'b1;
                    end
                end
                S_START: if (bus_done)
                    state <= (kind_q == K_READ) ? S_ADDR_R : S_ADDR_W;
                S_ADDR_W, S_ADDR_R: if (bus_done) begin
                    idx_q <= '0;
                    if (bus_nack) begin
                        err_nack <= 1'b1;
                        state    <= S_STOP;
                    end else begin
                        state <= (state == S_ADDR_W) ? S_WRITE : S_READ;
                    end
                end
                S_WRITE: if (bus_done) begin
                    if (bus_nack) begin
                        err_nack <= 1'b1;
                        state    <= S_STOP;
                    end else if (last_wr) begin
                        state <= (kind_q == K_COMBO) ? S_RSTART : S_STOP;
                    end else begin
                        idx_q <= idx_q + LEN_W'(1);
                    end
                end
                S_RSTART: if (bus_done) state <= S_ADDR_R;
                S_READ: if (bus_done) begin
                    if (last_rd) state <= S_STOP;
                    else         idx_q <= idx_q + LEN_W'(1);
                end
                S_STOP: if (bus_done) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Operation code and outgoing byte for the current state.
    always_comb begin
        bus_req     = (state != S_IDLE);
        bus_op      = OP_START;
        bus_wdata   = 8'h00;
        bus_rd_nack = 1'b0;
        case (state)
            S_ADDR_W: begin bus_op = OP_WRITE; bus_wdata = {addr_q, 1'b0}; end
            S_ADDR_R: begin bus_op = OP_WRITE; bus_wdata = {addr_q, 1'b1}; end
            S_WRITE:  begin
                bus_op    = OP_WRITE;
                bus_wdata = cmd_data_q ? cmd_q : buf_rdata;
            end
            S_RSTART: bus_op = OP_RSTART;
            S_READ:   begin bus_op = OP_READ; bus_rd_nack = last_rd; end
            S_STOP:   bus_op = OP_STOP;
            default:  bus_op = OP_START;
        endcase
    end

    // R6: an illegal descriptor ends at once without touching the bus.
    p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && desc_valid && !legal) |=> (done && err_desc && !bus_req && !busy));

    // R7: a NACK on any written byte is followed by stop.
    p_nack_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done && bus_nack && bus_op == OP_WRITE) |=> (bus_op == OP_STOP && err_nack));

    // R8: every transfer opens with a start; done never overlaps activity.
    p_start_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bus_req && bus_op == OP_START));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bus_req));

    // R3: the buffer is written only when a read byte completes.
    p_we_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (bus_req && bus_op == OP_READ && bus_done));

    // R5: a NACK request appears only on a read operation.
    p_rd_nack_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_nack |-> (bus_op == OP_READ));

endmodule

// File: tb/tb_i2c_desc_seq.sv
`timescale 1ns/1ps
module tb_i2c_desc_seq;
    import i2c_desc_pkg::*;

    localparam int LEN_W = 6;
    localparam int PTR_W = 6;
    localparam int BUF_N = 1 << PTR_W;

    typedef struct packed {
        logic [6:0] addr;
        logic       flag;
        logic [7:0] cmd;
        logic [5:0] wr;
        logic [5:0] rd;
        logic       rw;
        logic       blk;
        logic       pec;
        logic [5:0] ptr;
        logic [7:0] nack_at;   // operation index refused by target, FF = none
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{7'h21, 1'b1, 8'h5A, 6'd0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'hFF}, // R1
        '{7'h3B, 1'b0, 8'h00, 6'd3, 6'd0, 1'b0, 1'b0, 1'b0, 6'd4,  8'hFF}, // R2
        '{7'h50, 1'b0, 8'h00, 6'd0, 6'd4, 1'b1, 1'b0, 1'b0, 6'd10, 8'hFF}, // R3
        '{7'h11, 1'b0, 8'h00, 6'd2, 6'd3, 1'b1, 1'b0, 1'b0, 6'd20, 8'hFF}, // R4
        '{7'h22, 1'b0, 8'h00, 6'd1, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'hFF}, // R6 wr=1
        '{7'h22, 1'b0, 8'h00, 6'd2, 6'd0, 1'b0, 1'b1, 1'b0, 6'd0,  8'hFF}, // R6 blk
        '{7'h22, 1'b0, 8'h00, 6'd0, 6'd2, 1'b1, 1'b0, 1'b1, 6'd0,  8'hFF}, // R6 pec
        '{7'h22, 1'b1, 8'h77, 6'd0, 6'd0, 1'b1, 1'b0, 1'b0, 6'd0,  8'hFF}, // R6 cmd+rw
        '{7'h6C, 1'b0, 8'h00, 6'd3, 6'd0, 1'b0, 1'b0, 1'b0, 6'd8,  8'h01}, // R7 addr
        '{7'h0F, 1'b0, 8'h00, 6'd2, 6'd2, 1'b1, 1'b0, 1'b0, 6'd30, 8'h03}, // R7 last wr
        '{7'h7E, 1'b0, 8'h00, 6'd0, 6'd1, 1'b1, 1'b0, 1'b0, 6'd40, 8'hFF}, // R5 single
        '{7'h01, 1'b0, 8'h00, 6'd2, 6'd0, 1'b0, 1'b0, 1'b0, 6'd63, 8'hFF}  // R2 wrap
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             desc_valid = 1'b0;
    logic [6:0]       desc_addr = '0;
    logic             desc_cmd_data = 1'b0;
    logic [7:0]       desc_cmd = '0;
    logic [LEN_W-1:0] desc_wr_len = '0, desc_rd_len = '0;
    logic             desc_rw = 1'b0, desc_blk = 1'b0, desc_pec = 1'b0;
    logic [PTR_W-1:0] desc_ptr = '0;
    logic busy, done, err_desc, err_nack, bus_req, bus_rd_nack, buf_we;
    logic [2:0] bus_op;
    logic [7:0] bus_wdata, buf_rdata, buf_wdata;
    logic [PTR_W-1:0] buf_addr;
    logic bus_done, bus_nack;
    logic [7:0] bus_rdata;

    i2c_desc_seq #(.LEN_W(LEN_W), .PTR_W(PTR_W)) dut (
        .clk, .rst_n, .desc_valid, .desc_addr, .desc_cmd_data, .desc_cmd,
        .desc_wr_len, .desc_rd_len, .desc_rw, .desc_blk, .desc_pec, .desc_ptr,
        .busy, .done, .err_desc, .err_nack, .bus_req, .bus_op, .bus_wdata,
        .bus_rd_nack, .bus_done, .bus_nack, .bus_rdata, .buf_addr, .buf_rdata,
        .buf_we, .buf_wdata
    );

    // Buffer model: combinational read, clocked write, known fill at reset.
    logic [7:0] mem [BUF_N];
    assign buf_rdata = mem[buf_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_N; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (buf_we) begin
            mem[buf_addr] <= buf_wdata;
        end
    end

    // Bus engine model: records each request, answers two cycles later.
    logic [2:0] tr_op  [512];
    logic [7:0] tr_dat [512];
    logic       tr_nk  [512];
    logic [9:0] tr_n = '0;
    logic [9:0] cur = '0;
    logic       pend = 1'b0;
    logic [1:0] lat = '0;
    int         nack_abs = -1;
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_done <= 1'b0; bus_nack <= 1'b0; bus_rdata <= '0; pend <= 1'b0;
        end else begin
            bus_done <= 1'b0;
            bus_nack <= 1'b0;
            if (!pend && bus_req && !bus_done) begin
                tr_op[tr_n]  <= bus_op;
                tr_dat[tr_n] <= bus_wdata;
                tr_nk[tr_n]  <= bus_rd_nack;
                cur  <= tr_n;
                tr_n <= tr_n + 10'd1;
                pend <= 1'b1;
                lat  <= 2'd1;
            end else if (pend) begin
                if (lat == 2'd0) begin
                    bus_done  <= 1'b1;
                    bus_nack  <= (int'(cur) == nack_abs);
                    bus_rdata <= 8'hC0 + cur[7:0];
                    pend      <= 1'b0;
                end else begin
                    lat <= lat - 2'd1;
                end
            end
        end
    end

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected-behaviour model built from the requirements.
    logic [2:0] e_op  [64];
    logic [7:0] e_dat [64];
    logic       e_nk  [64];
    int  e_n, e_rd_n;
    int  e_rdidx [64];
    bit  e_legal, e_nackerr;
    logic [7:0] snap [BUF_N];

    function automatic void push(logic [2:0] op, logic [7:0] d, logic nk);
        e_op[e_n] = op; e_dat[e_n] = d; e_nk[e_n] = nk; e_n++;
    endfunction

    function automatic void build(vec_t v, int nk);
        bit pure_rd;
        int wn;
        e_n = 0; e_rd_n = 0; e_nackerr = 0;
        e_legal = !v.blk && !v.pec && (
            ( v.flag && v.wr == 0 && v.rd == 0 && !v.rw) ||
            (!v.flag && v.wr >= 2 && v.rd == 0 && !v.rw) ||
            (!v.flag && v.wr == 0 && v.rd != 0 &&  v.rw) ||
            (!v.flag && v.wr != 0 && v.rd != 0 &&  v.rw));
        if (!e_legal) return;
        pure_rd = !v.flag && v.wr == 0;
        push(3'(OP_START), 8'h00, 1'b0);
        push(3'(OP_WRITE), {v.addr, pure_rd}, 1'b0);
        if (e_n - 1 == nk) begin e_nackerr = 1; push(3'(OP_STOP), 8'h00, 1'b0); return; end
        if (!pure_rd) begin
            wn = v.flag ? 1 : int'(v.wr);
            for (int i = 0; i < wn; i++) begin
                push(3'(OP_WRITE), v.flag ? v.cmd : snap[(int'(v.ptr) + i) % BUF_N], 1'b0);
                if (e_n - 1 == nk) begin e_nackerr = 1; push(3'(OP_STOP), 8'h00, 1'b0); return; end
            end
        end
        if (v.rd != 0) begin
            if (!pure_rd) begin
                push(3'(OP_RSTART), 8'h00, 1'b0);
                push(3'(OP_WRITE), {v.addr, 1'b1}, 1'b0);
                if (e_n - 1 == nk) begin e_nackerr = 1; push(3'(OP_STOP), 8'h00, 1'b0); return; end
            end
            for (int i = 0; i < int'(v.rd); i++) begin
                push(3'(OP_READ), 8'h00, (i == int'(v.rd) - 1));
                e_rdidx[e_rd_n] = e_n - 1;
                e_rd_n++;
            end
        end
        push(3'(OP_STOP), 8'h00, 1'b0);
    endfunction

    task automatic drive(vec_t v);
        desc_addr = v.addr; desc_cmd_data = v.flag; desc_cmd = v.cmd;
        desc_wr_len = v.wr; desc_rd_len = v.rd; desc_rw = v.rw;
        desc_blk = v.blk; desc_pec = v.pec; desc_ptr = v.ptr;
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic run_vec(vec_t v, string tag);
        int base, nk, cyc, bad_op, bad_nk, bad_mem, k;
        bit busy_ok, prev_stop;
        logic [7:0] expm;
        @(negedge clk);
        while (busy) @(negedge clk);
        for (int i = 0; i < BUF_N; i++) snap[i] = mem[i];
        base = int'(tr_n);
        nk = (v.nack_at == 8'hFF) ? -1 : int'(v.nack_at);
        nack_abs = (nk < 0) ? -1 : base + nk;
        build(v, nk);
        drive(v);
        busy_ok = 1; prev_stop = 0; cyc = 0;
        while (!done && cyc < 3000) begin
            if (!busy) busy_ok = 0;
            prev_stop = (bus_op == 3'(OP_STOP)) && bus_done;
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R8", {tag, " done pulse"}, done, 1);
        chk(err_desc == !e_legal, "R6", {tag, " err_desc"}, err_desc, !e_legal);
        chk(err_nack == e_nackerr, "R7", {tag, " err_nack"}, err_nack, e_nackerr);
        if (e_legal)
            chk(busy_ok && prev_stop, "R8", {tag, " busy until stop done"},
                {busy_ok, prev_stop}, 2'b11);
        chk(int'(tr_n) - base == e_n, tag, "operation count", int'(tr_n) - base, e_n);
        bad_op = -1; bad_nk = -1;
        for (int i = 0; i < e_n && i < int'(tr_n) - base; i++) begin
            if (tr_op[base + i] != e_op[i] ||
                (e_op[i] == 3'(OP_WRITE) && tr_dat[base + i] != e_dat[i]))
                if (bad_op < 0) bad_op = i;
            if (e_op[i] == 3'(OP_READ) && tr_nk[base + i] != e_nk[i])
                if (bad_nk < 0) bad_nk = i;
        end
        chk(bad_op < 0, tag, "operation/byte sequence (R9 codes)",
            bad_op < 0 ? 0 : {tr_op[base + bad_op], tr_dat[base + bad_op]},
            bad_op < 0 ? 0 : {e_op[bad_op], e_dat[bad_op]});
        if (e_rd_n > 0)
            chk(bad_nk < 0, "R5", {tag, " read ack/nack"}, bad_nk, -1);
        bad_mem = -1;
        for (int i = 0; i < BUF_N; i++) begin
            expm = snap[i];
            for (int r = 0; r < e_rd_n; r++)
                if ((int'(v.ptr) + r) % BUF_N == i) expm = 8'hC0 + 8'(base + e_rdidx[r]);
            if (mem[i] != expm && bad_mem < 0) bad_mem = i;
        end
        k = bad_mem < 0 ? 0 : bad_mem;
        chk(bad_mem < 0, e_rd_n > 0 ? "R3/R4" : tag, {tag, " buffer contents"},
            mem[k], bad_mem);
        @(negedge clk);
        chk(done == 1'b0, "R8", {tag, " done one cycle"}, done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    string tags [NV] = '{"R1", "R2", "R3", "R4", "R6", "R6", "R6", "R6",
                         "R7", "R7", "R5", "R2"};

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // Reset state (R8)
        chk(!busy && !done && !bus_req && !err_desc && !err_nack, "R8",
            "reset state", {busy, done, bus_req, err_desc, err_nack}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], tags[i]);

        // R8: a descriptor offered while busy is ignored.
        v = VECS[2];
        fork
            run_vec(v, "R8-busy");
            begin
                repeat (8) @(negedge clk);
                desc_blk = 1'b1; desc_valid = 1'b1;
                @(negedge clk);
                desc_valid = 1'b0; desc_blk = 1'b0;
            end
        join
        chk(err_desc == 1'b0, "R8", "desc while busy ignored", err_desc, 0);

        // R8: reset in mid-transfer returns to idle with no request.
        v = VECS[1];
        drive(v);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !bus_req && !done && !err_nack, "R8", "reset mid-transfer",
            {busy, bus_req, done, err_nack}, 0);
        rst_n = 1'b1;
        run_vec(VECS[0], "R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule